// File: doc/BRIEF.md
# Selectable-Frequency PWM Gate Timer

This block times the two gate enables of a synchronous buck power stage from a fast system clock. A two-bit selector picks one of three switching periods, and a duty word gives the high-side on-time in clock cycles. Around every high-side pulse the block keeps both gates off for a fixed number of cycles, so the two switches never conduct together. A one-cycle strobe marks the first cycle of every switching period.

For light loads, a skip request drops whole switching periods with both gates off. When the audio-floor option is on, the block still forces a pulse before the gap between pulses could exceed a set number of cycles, which keeps the pulse rate above the audible band. The selector, duty word, skip request and audio-floor option are sampled once per period, on its last cycle. Dropping the enable turns both gates off at once. With the default parameters and a 100 MHz clock, the three periods are 166, 125 and 100 cycles, which give about 600, 800 and 1000 kHz. The dead time is then 2 cycles and the audio floor is 2500 cycles (25 µs). After reset the period register holds the middle setting.

Top module: `pwm_gate_timer`

## Requirements
- R1: Successive `cycle_start` strobes are P_LOW cycles apart when `freq_sel` is 2'b00, P_MID cycles apart for 2'b01 and P_HIGH cycles apart for 2'b10.
- R2: The reserved selector value 2'b11 gives the same period as 2'b01 (P_MID).
- R3: `freq_sel`, `duty`, `skip_req` and `audio_floor_en` are sampled once per period, on its last cycle. A change made during a period only shapes the next period.
- R4: Count phase j from 0 in the strobe cycle, which is the only strobe of the period. In a period that fires, both gates are low for j < DEAD. `gate_hi` is high for DEAD <= j < DEAD+on. Both gates are low for the next DEAD cycles. `gate_lo` is high from j = 2*DEAD+on to the end of the period.
- R5: The on-time is min(duty, period - 2*DEAD), so the pulse and both dead times always fit inside the period.
- R6: `gate_hi` and `gate_lo` are never high together. Before each rising edge of either gate, both gates have been low for at least DEAD cycles.
- R7: A period fails to fire if `skip_req` is 1 or the clamped on-time is 0, unless R8 forces it. Such a period keeps both gates low throughout but still has its strobe.
- R8: With `audio_floor_en` = 1, a period that would be skipped fires anyway if the cycles since the start of the last firing period plus the new period exceed AUDIO_CNT. A forced period uses the clamped on-time, or 1 cycle if that is 0. Under a constant skip request with period P, firing periods start every floor(AUDIO_CNT/P)*P cycles.
- R9: While `enable` is 0, all three outputs are 0, starting in the same cycle in which `enable` falls. After `enable` rises, the first strobe appears after the second rising clock edge and starts a fresh period.
- R10: Synchronous active-high `rst` drives all outputs to 0 and clears the counters, whatever `enable` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run enable; when 0, both gates are off at once |
| freq_sel | input | 2 | Switching period select (00 low, 01 mid, 10 high, 11 mid) |
| duty | input | DUTY_W | Requested high-side on-time in clock cycles |
| skip_req | input | 1 | Request to drop the next switching period |
| audio_floor_en | input | 1 | Bounds the gap between pulses to AUDIO_CNT cycles |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| cycle_start | output | 1 | One-cycle strobe on the first cycle of each period |

## Verification
The audio-floor override and the duty clamp can both act at the same period boundary: a forced pulse must carry the clamped on-time, and a zero duty must become a one-cycle pulse. The bench holds a skip request with the floor enabled, for each frequency, with duties above the limit, inside it and at zero. At each boundary it judges the spacing between pulse starts, the high-side width and the number of low-side cycles against values worked out from the period, the dead time and AUDIO_CNT. A full sweep of selector and duty values without skipping checks every cycle of every period. A mid-pulse enable drop checks that the gates turn off in the same cycle.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

  typedef enum logic [1:0] {
    FREQ_LOW  = 2'b00,
    FREQ_MID  = 2'b01,
    FREQ_HIGH = 2'b10,
    FREQ_RSVD = 2'b11
  } freq_sel_e;

  typedef struct packed {
    logic hi;
    logic lo;
    logic start;
  } gate_word_t;

endpackage

// File: rtl/pwm_period_sel.sv
module pwm_period_sel
  import pwm_gate_pkg::*;
#(
  parameter int P_LOW  = 166,
  parameter int P_MID  = 125,
  parameter int P_HIGH = 100,
  parameter int CNT_W  = 8
) (
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] period
);

  // Reserved code falls through to the middle setting.
  always_comb begin
    case (freq_sel_e'(sel))
      FREQ_LOW:  period = CNT_W'(P_LOW);
      FREQ_HIGH: period = CNT_W'(P_HIGH);
      default:   period = CNT_W'(P_MID);
    endcase
  end

endmodule

// File: rtl/pwm_duty_clamp.sv
module pwm_duty_clamp #(
  parameter int DUTY_W = 8,
  parameter int CNT_W  = 8,
  parameter int DEAD   = 2
) (
  input  logic [DUTY_W-1:0] duty,
  input  logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  on_time
);

  localparam int CW = ((DUTY_W > CNT_W) ? DUTY_W : CNT_W) + 1;

  logic [CW-1:0] duty_w;
  logic [CW-1:0] limit_w;

  assign duty_w  = CW'(duty);
  assign limit_w = CW'(period) - CW'(2 * DEAD);

  // The pulse plus both guard gaps must fit inside the period.
  assign on_time = (duty_w > limit_w) ? CNT_W'(limit_w) : CNT_W'(duty_w);

endmodule

// File: rtl/pwm_skip_ctrl.sv
module pwm_skip_ctrl #(
  parameter int CNT_W     = 8,
  parameter int AUDIO_CNT = 2500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             boundary,
  input  logic             audio_en,
  input  logic             skip_req,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] on_raw,
  output logic             fire,
  output logic [CNT_W-1:0] on_eff
);

  localparam int SINCE_W = $clog2(AUDIO_CNT + 1);
  localparam int SUM_W   = ((SINCE_W > CNT_W) ? SINCE_W : CNT_W) + 1;

  logic [SINCE_W-1:0] since_q;
  logic [SUM_W-1:0]   reach;
  logic               want_skip;
  logic               force_pulse;

  // Start of the period after next, measured from the last firing start.
  assign reach       = SUM_W'(since_q) + SUM_W'(period);
  assign force_pulse = audio_en && (reach > SUM_W'(AUDIO_CNT));
  assign want_skip   = skip_req || (on_raw == '0);
  assign fire        = !want_skip || force_pulse;
  assign on_eff      = (on_raw == '0) ? CNT_W'(1) : on_raw;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      since_q <= '0;
    end else if (boundary && fire) begin
      since_q <= SINCE_W'(1);
    end else if (since_q != SINCE_W'(AUDIO_CNT)) begin
      since_q <= since_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
  import pwm_gate_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DEAD    = 2,
  parameter int RST_PER = 125
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] on_in,
  input  logic             fire_in,
  output logic             boundary,
  output gate_word_t       word_q
);

  localparam int SUM_W = CNT_W + 2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] on_q;
  logic             fire_q;
  logic             run_q;
  logic [SUM_W-1:0] phase;
  logic [SUM_W-1:0] hi_from;
  logic [SUM_W-1:0] hi_to;
  logic [SUM_W-1:0] lo_from;
  gate_word_t       dec;

  assign boundary = enable && (!run_q || (cnt_q == per_q - 1'b1));

  assign phase   = SUM_W'(cnt_q);
  assign hi_from = SUM_W'(DEAD);
  assign hi_to   = SUM_W'(DEAD) + SUM_W'(on_q);
  assign lo_from = hi_to + SUM_W'(DEAD);

  always_comb begin
    dec.start = run_q && (cnt_q == '0);
    dec.hi    = run_q && fire_q && (phase >= hi_from) && (phase < hi_to);
    dec.lo    = run_q && fire_q && (phase >= lo_from);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      per_q  <= CNT_W'(RST_PER);
      on_q   <= '0;
      fire_q <= 1'b0;
      run_q  <= 1'b0;
      word_q <= '0;
    end else if (!enable) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
      run_q  <= 1'b0;
      word_q <= '0;
    end else begin
      word_q <= dec;
      if (boundary) begin
        cnt_q  <= '0;
        per_q  <= period_in;
        on_q   <= on_in;
        fire_q <= fire_in;
        run_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_gate_timer.sv
module pwm_gate_timer
  import pwm_gate_pkg::*;
#(
  parameter int P_LOW     = 166,
  parameter int P_MID     = 125,
  parameter int P_HIGH    = 100,
  parameter int DEAD      = 2,
  parameter int DUTY_W    = 8,
  parameter int AUDIO_CNT = 2500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [1:0]        freq_sel,
  input  logic [DUTY_W-1:0] duty,
  input  logic              skip_req,
  input  logic              audio_floor_en,
  output logic              gate_hi,
  output logic              gate_lo,
  output logic              cycle_start
);

  localparam int P_MAX_LM = (P_LOW > P_MID) ? P_LOW : P_MID;
  localparam int P_MAX    = (P_MAX_LM > P_HIGH) ? P_MAX_LM : P_HIGH;
  localparam int CNT_W    = $clog2(P_MAX + 1);

  logic [CNT_W-1:0] per_next;
  logic [CNT_W-1:0] on_raw;
  logic [CNT_W-1:0] on_eff;
  logic             fire;
  logic             boundary;
  gate_word_t       word_q;

  pwm_period_sel #(
    .P_LOW (P_LOW),
    .P_MID (P_MID),
    .P_HIGH(P_HIGH),
    .CNT_W (CNT_W)
  ) u_period_sel (
    .sel   (freq_sel),
    .period(per_next)
  );

  pwm_duty_clamp #(
    .DUTY_W(DUTY_W),
    .CNT_W (CNT_W),
    .DEAD  (DEAD)
  ) u_duty_clamp (
    .duty   (duty),
    .period (per_next),
    .on_time(on_raw)
  );

  pwm_skip_ctrl #(
    .CNT_W    (CNT_W),
    .AUDIO_CNT(AUDIO_CNT)
  ) u_skip_ctrl (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .boundary(boundary),
    .audio_en(audio_floor_en),
    .skip_req(skip_req),
    .period  (per_next),
    .on_raw  (on_raw),
    .fire    (fire),
    .on_eff  (on_eff)
  );

  pwm_phase_gen #(
    .CNT_W  (CNT_W),
    .DEAD   (DEAD),
    .RST_PER(P_MID)
  ) u_phase_gen (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .period_in(per_next),
    .on_in    (on_eff),
    .fire_in  (fire),
    .boundary (boundary),
    .word_q   (word_q)
  );

  // Registered drive, cut by enable without waiting for an edge.
  assign gate_hi     = word_q.hi & enable;
  assign gate_lo     = word_q.lo & enable;
  assign cycle_start = word_q.start & enable;

endmodule

// File: rtl/pwm_gate_timer_chk.sv
module pwm_gate_timer_chk #(
  parameter int DEAD      = 2,
  parameter int AUDIO_CNT = 2500,
  parameter int P_LOW     = 166,
  parameter int P_MID     = 125,
  parameter int P_HIGH    = 100
) (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic audio_floor_en,
  input logic gate_hi,
  input logic gate_lo,
  input logic cycle_start
);

  localparam int P_MAX_LM = (P_LOW > P_MID) ? P_LOW : P_MID;
  localparam int P_MAX    = (P_MAX_LM > P_HIGH) ? P_MAX_LM : P_HIGH;
  localparam int GAP_MAX  = AUDIO_CNT + P_MAX + DEAD + 4;

  int   idle_q;
  int   since_strobe_q;
  int   gap_q;
  logic hi_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q         <= 0;
      since_strobe_q <= 0;
      gap_q          <= 0;
      hi_d           <= 1'b0;
    end else begin
      hi_d <= gate_hi;
      if (gate_hi || gate_lo) idle_q <= 0;
      else if (idle_q < DEAD) idle_q <= idle_q + 1;
      if (cycle_start) since_strobe_q <= 1;
      else if (since_strobe_q < 65535) since_strobe_q <= since_strobe_q + 1;
      if (!enable || !audio_floor_en || (gate_hi && !hi_d)) gap_q <= 0;
      else if (gap_q <= GAP_MAX) gap_q <= gap_q + 1;
    end
  end

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
    !(gate_hi && gate_lo));

  p_dead_gap_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_hi) || $rose(gate_lo)) |-> (idle_q >= DEAD));

  p_hi_offset_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi) |-> (since_strobe_q == DEAD));

  p_idle_disabled_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> (!gate_hi && !gate_lo && !cycle_start));

  p_audio_floor_r8: assert property (@(posedge clk) disable iff (rst)
    (enable && audio_floor_en) |-> (gap_q <= GAP_MAX));

endmodule

bind pwm_gate_timer pwm_gate_timer_chk #(
  .DEAD     (DEAD),
  .AUDIO_CNT(AUDIO_CNT),
  .P_LOW    (P_LOW),
  .P_MID    (P_MID),
  .P_HIGH   (P_HIGH)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .enable        (enable),
  .audio_floor_en(audio_floor_en),
  .gate_hi       (gate_hi),
  .gate_lo       (gate_lo),
  .cycle_start   (cycle_start)
);

// File: tb/test_pwm_gate_timer.sv
module test_pwm_gate_timer;

  localparam int PL = 12;
  localparam int PM = 10;
  localparam int PH = 8;
  localparam int DT = 2;
  localparam int DW = 4;
  localparam int AL = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic [1:0]    freq_sel = 2'd1;
  logic [DW-1:0] duty = '0;
  logic          skip_req = 1'b0;
  logic          audio_floor_en = 1'b0;
  logic          gate_hi;
  logic          gate_lo;
  logic          cycle_start;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pwm_gate_timer #(
    .P_LOW(PL), .P_MID(PM), .P_HIGH(PH), .DEAD(DT), .DUTY_W(DW), .AUDIO_CNT(AL)
  ) i_pwm_gate_timer (
    .clk(clk), .rst(rst), .enable(enable), .freq_sel(freq_sel), .duty(duty),
    .skip_req(skip_req), .audio_floor_en(audio_floor_en),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .cycle_start(cycle_start)
  );

  function automatic int per_of(input int fs);
    if (fs == 0) return PL;
    if (fs == 2) return PH;
    return PM;
  endfunction

  function automatic int on_of(input int fs, input int d);
    int lim;
    lim = per_of(fs) - 2 * DT;
    return (d < lim) ? d : lim;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Entered at the strobe cycle of a period built from (fs,d,sk); the next
  // settings are driven in that cycle and must only shape the next period.
  task automatic run_period(input int fs, input int d, input bit sk,
                            input int nfs, input int nd, input bit nsk);
    int    p, on, bad_j, act_v, exp_v;
    bit    fire, eh, el, es, mism;
    string req;
    p = per_of(fs);
    on = on_of(fs, d);
    fire = !sk && (on > 0);
    req = !fire ? "R7" : ((d > p - 2 * DT) ? "R5" : "R4");
    mism = 1'b0; bad_j = -1; act_v = 0; exp_v = 0;
    for (int j = 0; j < p; j++) begin
      if (j > 0) @(negedge clk);
      eh = fire && (j >= DT) && (j < DT + on);
      el = fire && (j >= 2 * DT + on);
      es = (j == 0);
      if (!mism && (gate_hi !== eh || gate_lo !== el || cycle_start !== es)) begin
        mism  = 1'b1;
        bad_j = j;
        act_v = int'({gate_hi, gate_lo, cycle_start});
        exp_v = int'({eh, el, es});
      end
      if (j == 0) begin
        freq_sel = 2'(nfs);
        duty     = DW'(nd);
        skip_req = nsk;
      end
    end
    check(!mism, req, $sformatf("pattern fs=%0d duty=%0d skip=%0d phase %0d {hi,lo,start}",
          fs, d, sk, bad_j), act_v, exp_v);
    @(negedge clk);
    check(cycle_start === 1'b1, (fs == 3) ? "R2" : "R1",
          $sformatf("period length %0d for sel=%0d (R3 next setting waits for boundary)", p, fs),
          int'(cycle_start), 1);
  endtask

  // Constant skip with the audio floor on: spacing, width and low-side count.
  task automatic audio_run(input int fs, input int d);
    int p, w_exp, gap_exp, idx, r1, r2, wcnt, lcnt;
    bit prev;
    p = per_of(fs);
    w_exp = on_of(fs, d);
    if (w_exp < 1) w_exp = 1;
    gap_exp = (AL / p) * p;
    @(negedge clk);
    freq_sel = 2'(fs); duty = DW'(d); skip_req = 1'b1; audio_floor_en = 1'b1;
    repeat (3 * AL) @(negedge clk);
    prev = gate_hi; idx = 0; r1 = -1; r2 = -1; wcnt = 0; lcnt = 0;
    while (r1 < 0 && idx < 400) begin
      @(negedge clk); idx++;
      if (gate_hi && !prev) r1 = idx;
      prev = gate_hi;
    end
    while (r2 < 0 && idx < 800) begin
      if (gate_hi) wcnt++;
      if (gate_lo) lcnt++;
      @(negedge clk); idx++;
      if (gate_hi && !prev) r2 = idx;
      prev = gate_hi;
    end
    check((r2 - r1) == gap_exp, "R8", $sformatf("pulse spacing sel=%0d duty=%0d", fs, d),
          r2 - r1, gap_exp);
    check(wcnt == w_exp, "R8", $sformatf("forced high width (R5 clamp) sel=%0d duty=%0d", fs, d),
          wcnt, w_exp);
    check(lcnt == p - 2 * DT - w_exp, "R8", $sformatf("low-side cycles sel=%0d duty=%0d", fs, d),
          lcnt, p - 2 * DT - w_exp);
  endtask

  initial begin
    int cfs, cd;
    bit csk;
    // Reset holds the outputs low even with enable high.
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check(!gate_hi && !gate_lo && !cycle_start, "R10", "outputs during reset",
          int'({gate_hi, gate_lo, cycle_start}), 0);
    enable = 1'b0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!gate_hi && !gate_lo && !cycle_start, "R9", "outputs while disabled",
          int'({gate_hi, gate_lo, cycle_start}), 0);
    enable = 1'b1; freq_sel = 2'd1; duty = '0;
    @(negedge clk);
    check(cycle_start === 1'b0, "R9", "no strobe after first edge", int'(cycle_start), 0);
    @(negedge clk);
    check(cycle_start === 1'b1, "R9", "strobe after second edge", int'(cycle_start), 1);

    cfs = 1; cd = 0; csk = 1'b0;
    for (int fs = 0; fs < 4; fs++) begin
      for (int d = 0; d < 16; d++) begin
        run_period(cfs, cd, csk, fs, d, 1'b0);
        cfs = fs; cd = d; csk = 1'b0;
      end
    end
    for (int fs = 0; fs < 3; fs++) begin
      run_period(cfs, cd, csk, fs, 9, 1'b1);
      cfs = fs; cd = 9; csk = 1'b1;
    end
    run_period(cfs, cd, csk, 1, 5, 1'b0);
    cfs = 1; cd = 5; csk = 1'b0;
    run_period(cfs, cd, csk, 1, 5, 1'b0);

    audio_run(0, 15);
    audio_run(1, 0);
    audio_run(2, 3);
    audio_run(2, 15);

    // Enable drop in the middle of a high-side pulse.
    @(negedge clk);
    skip_req = 1'b0; audio_floor_en = 1'b0; freq_sel = 2'd1; duty = DW'(5);
    while (!cycle_start) @(negedge clk);
    @(negedge clk);
    while (!cycle_start) @(negedge clk);
    repeat (DT + 1) @(negedge clk);
    check(gate_hi === 1'b1, "R4", "high side on before enable drop", int'(gate_hi), 1);
    enable = 1'b0;
    #1;
    check(!gate_hi && !gate_lo, "R9", "gates off in the cycle enable falls",
          int'({gate_hi, gate_lo}), 0);
    repeat (5) @(negedge clk);
    check(!gate_hi && !gate_lo && !cycle_start, "R9", "outputs stay off while disabled",
          int'({gate_hi, gate_lo, cycle_start}), 0);
    enable = 1'b1;
    @(negedge clk);
    check(cycle_start === 1'b0, "R9", "no strobe one edge after re-enable", int'(cycle_start), 0);
    @(negedge clk);
    check(cycle_start === 1'b1, "R9", "fresh strobe after re-enable", int'(cycle_start), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all requirements: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule